// File: doc/BRIEF.md
# Clock Watchdog with Safe-Frequency Fallback

This block supervises the frequency-select code that a programmable clock generator uses. In normal running it passes on a 5-bit frequency code. That code comes either from the strap value latched at power-on or from a frequency field that software programs. A countdown timer counts slow ticks, and a prescaler on the reference clock makes those ticks. The timer's count sets the timeout in units of one tick, and one tick stands for 290 ms in silicon. When the timer runs out, the block raises a sticky alarm. It then swaps the output for a safe code and drives an active-low system reset for a fixed number of reference cycles.

Software keeps the system alive by writing the timer value, which re-arms the countdown. A control byte holds a program-enable flag, a watchdog-enable flag, the alarm status and a programmed 5-bit safe code. The watchdog-enable flag overrides the strap enable once software has written the control byte. Software can also ask for the reset pulse on every change of the output code.

Top module: `freq_wd_top`

## Requirements
- R1: After reset, the control readback is 8'h1F (safe code all ones, all flags clear), the alarm is low and `sys_rst_n` is high. One clock after reset is released, `freq_sel` shows the selected normal code.
- R2: The normal code is `strap_code` when `mode_byte[0]` is 0. When `mode_byte[0]` is 1, the normal code is the programmed field {`mode_byte[2]`,`mode_byte[1]`,`mode_byte[6]`,`mode_byte[5]`,`mode_byte[4]`}, listed from MSB to LSB. `freq_sel` is registered and follows one clock after an input change.
- R3: A timer write of N re-arms the countdown and restarts the prescaler. The alarm rises N×TICK_DIV clocks after the write edge. An N of 0 or 1 expires at the first tick. The count is TMO_INIT after reset.
- R4: The watchdog-enable source is `strap_wd_en` until the first control write. From then on it is control bit 6. While the watchdog is disabled the countdown does not advance and no alarm occurs.
- R5: On expiry the alarm rises, and control readback bit 5 shows it.
- R6: While the alarm is set, `freq_sel` is the safe code. The safe code is `strap_code` when `mode_byte[3]` is 0 and control bits 4:0 when `mode_byte[3]` is 1.
- R7: Expiry drives `sys_rst_n` low for RST_LEN clocks, starting right after the expiry edge.
- R8: With `rst_on_chg` high, any change of the registered `freq_sel` starts a pulse of RST_LEN clocks. With `rst_on_chg` low, a code change leaves `sys_rst_n` high.
- R9: The alarm stays set until a timer write, or until a control write with bit 5 equal to 0. A control write with bit 5 equal to 1 leaves the alarm set.
- R10: A timer write in the same clock as the expiring tick wins. No alarm and no reset pulse follow, and the new count starts from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_code | input | 5 | Frequency code latched from straps at power-on |
| strap_wd_en | input | 1 | Watchdog enable latched from straps |
| mode_byte | input | 8 | Frequency mode byte: bit 0 program select, bit 3 safe select, split frequency field |
| rst_on_chg | input | 1 | Enables the reset pulse on a frequency code change |
| tmr_wr | input | 1 | Timer write strobe (re-arm) |
| tmr_wdata | input | CNT_W | Timer count in ticks |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte: 7 program enable, 6 watchdog enable, 5 alarm (write 0 clears), 4:0 safe code |
| freq_sel | output | 5 | Effective frequency select code |
| sys_rst_n | output | 1 | Active-low system reset pulse |
| alarm | output | 1 | Watchdog alarm status |
| ctl_q | output | 8 | Control byte readback, same layout as `ctl_wdata` |

## Verification
A software re-arm can land in the same clock as the tick that would end the countdown. The two actions then fight over the alarm, the counter and the reset generator. The bench arms a count of one tick and waits until one clock before expiry. It then places the next timer write exactly on the expiring edge. The bench judges the outcome by requiring the alarm to stay low and `sys_rst_n` to stay high. After that, a fresh expiry must arrive a full tick period after the colliding write.

// File: rtl/freq_wd_pkg.sv
package freq_wd_pkg;
  localparam int CODE_W = 5;
  localparam int CTL_PROG = 7;
  localparam int CTL_WDEN = 6;
  localparam int CTL_ALARM = 5;

  typedef logic [CODE_W-1:0] fcode_t;

  // programmed field is scattered: MSB..LSB = bits 2,1,6,5,4
  function automatic fcode_t field_code(input logic [7:0] b);
    return {b[2], b[1], b[6], b[5], b[4]};
  endfunction

  function automatic fcode_t pick_code(input logic use_alt, input fcode_t alt,
                                       input fcode_t strap);
    return use_alt ? alt : strap;
  endfunction
endpackage

// File: rtl/freq_wd_prescale.sv
module freq_wd_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [PW-1:0] pre_q;

  assign tick = run && (pre_q == PW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pre_q <= '0;
    else if (clear || !run)   pre_q <= '0;
    else if (tick)            pre_q <= '0;
    else                      pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/freq_wd_count.sv
module freq_wd_count #(
  parameter int CW   = 8,
  parameter int INIT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          step,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  assign last = (cnt_q <= CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= CW'(INIT);
    else if (load)                  cnt_q <= load_val;
    else if (step && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/freq_wd_rstgen.sv
module freq_wd_rstgen #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pulse_n
);
  localparam int LW = $clog2(LEN + 1);
  logic [LW-1:0] cnt_q;

  assign pulse_n = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= LW'(LEN);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/freq_wd_top.sv
module freq_wd_top
  import freq_wd_pkg::*;
#(
  parameter int unsigned TICK_DIV = 4152220,
  parameter int CNT_W    = 8,
  parameter int TMO_INIT = 16,
  parameter int RST_LEN  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       strap_code,
  input  logic             strap_wd_en,
  input  logic [7:0]       mode_byte,
  input  logic             rst_on_chg,
  input  logic             tmr_wr,
  input  logic [CNT_W-1:0] tmr_wdata,
  input  logic             ctl_wr,
  input  logic [7:0]       ctl_wdata,
  output logic [4:0]       freq_sel,
  output logic             sys_rst_n,
  output logic             alarm,
  output logic [7:0]       ctl_q
);
  logic   prog_q, wden_q, wden_own_q, alarm_q, primed_q;
  fcode_t safe_q, freq_q;

  // named internal events
  logic   wd_en, armed, tick, last, expire, chg_evt, rst_start;
  fcode_t normal_code, safe_code, freq_nxt;

  assign wd_en = wden_own_q ? wden_q : strap_wd_en;
  assign armed = wd_en && !alarm_q;

  freq_wd_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(armed), .clear(tmr_wr), .tick(tick)
  );

  freq_wd_count #(.CW(CNT_W), .INIT(TMO_INIT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(tmr_wr), .load_val(tmr_wdata),
    .step(tick), .last(last)
  );

  // a re-arm in the expiring cycle wins
  assign expire = tick && last && !tmr_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                alarm_q <= 1'b0;
    else if (tmr_wr)                           alarm_q <= 1'b0;
    else if (expire)                           alarm_q <= 1'b1;
    else if (ctl_wr && !ctl_wdata[CTL_ALARM])  alarm_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q     <= 1'b0;
      wden_q     <= 1'b0;
      wden_own_q <= 1'b0;
      safe_q     <= '1;
    end else if (ctl_wr) begin
      prog_q     <= ctl_wdata[CTL_PROG];
      wden_q     <= ctl_wdata[CTL_WDEN];
      wden_own_q <= 1'b1;
      safe_q     <= ctl_wdata[CODE_W-1:0];
    end
  end

  assign normal_code = pick_code(mode_byte[0], field_code(mode_byte), strap_code);
  assign safe_code   = pick_code(mode_byte[3], safe_q, strap_code);
  assign freq_nxt    = alarm_q ? safe_code : normal_code;
  assign chg_evt     = primed_q && rst_on_chg && (freq_nxt != freq_q);
  assign rst_start   = expire || chg_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      freq_q   <= freq_nxt;
      primed_q <= 1'b1;
    end
  end

  freq_wd_rstgen #(.LEN(RST_LEN)) u_rst (
    .clk(clk), .rst_n(rst_n), .start(rst_start), .pulse_n(sys_rst_n)
  );

  assign freq_sel = freq_q;
  assign alarm    = alarm_q;
  assign ctl_q    = {prog_q, wden_q, alarm_q, safe_q};
endmodule

// File: rtl/freq_wd_chk.sv
module freq_wd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tmr_wr,
  input logic       ctl_wr,
  input logic [7:0] ctl_wdata,
  input logic       alarm,
  input logic       sys_rst_n,
  input logic [4:0] freq_sel,
  input logic [4:0] safe_code,
  input logic       expire,
  input logic       rst_start
);
  AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wr |=> !alarm); // R10

  AST_EXPIRY_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (alarm && !sys_rst_n)); // R7

  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !tmr_wr && !(ctl_wr && !ctl_wdata[5])) |=> alarm); // R9

  AST_SAFE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |=> (freq_sel == $past(safe_code))); // R6

  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_n) |-> $past(rst_start)); // R8
endmodule

bind freq_wd_top freq_wd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_wr(tmr_wr), .ctl_wr(ctl_wr),
  .ctl_wdata(ctl_wdata), .alarm(alarm), .sys_rst_n(sys_rst_n),
  .freq_sel(freq_sel), .safe_code(safe_code), .expire(expire),
  .rst_start(rst_start)
);

// File: tb/freq_wd_top_tb_top.sv
module freq_wd_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TD  = 8;
  localparam int RL  = 4;
  localparam int NV  = 6;
  // {mode_byte, strap_code, expected freq_sel}
  localparam logic [17:0] VEC [NV] = '{
    {8'h00, 5'h0A, 5'h0A},
    {8'h65, 5'h03, 5'h16},
    {8'h57, 5'h00, 5'h1D},
    {8'h56, 5'h11, 5'h11},
    {8'h1F, 5'h07, 5'h19},
    {8'h13, 5'h1F, 5'h09}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] strap_code = 5'h0A;
  logic       strap_wd_en = 1'b0;
  logic [7:0] mode_byte = 8'h00;
  logic       rst_on_chg = 1'b0;
  logic       tmr_wr = 1'b0;
  logic [7:0] tmr_wdata = 8'h00;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [4:0] freq_sel;
  logic       sys_rst_n, alarm;
  logic [7:0] ctl_q;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  freq_wd_top #(.TICK_DIV(TD), .CNT_W(8), .TMO_INIT(16), .RST_LEN(RL)) dut_i (
    .clk(clk), .rst_n(rst_n), .strap_code(strap_code), .strap_wd_en(strap_wd_en),
    .mode_byte(mode_byte), .rst_on_chg(rst_on_chg), .tmr_wr(tmr_wr),
    .tmr_wdata(tmr_wdata), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .freq_sel(freq_sel), .sys_rst_n(sys_rst_n), .alarm(alarm), .ctl_q(ctl_q)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: run hung act=%0d exp=<20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_tmr(input logic [7:0] v);
    tmr_wr = 1'b1; tmr_wdata = v;
    @(negedge clk);
    tmr_wr = 1'b0;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  initial begin
    nclk(3);
    chk("R1 rst alarm", {7'd0, alarm}, 8'h0);
    chk("R1 rst sys_rst_n", {7'd0, sys_rst_n}, 8'h1);
    chk("R1 rst ctl_q", ctl_q, 8'h1F);
    rst_n = 1'b1;
    nclk(1);
    chk("R1 first code", {3'd0, freq_sel}, 8'h0A);

    // R2 code selection table
    for (int v = 0; v < NV; v++) begin
      mode_byte  = VEC[v][17:10];
      strap_code = VEC[v][9:5];
      nclk(1);
      chk("R2 code select", {3'd0, freq_sel}, {3'd0, VEC[v][4:0]});
      chk("R8 no pulse when disabled", {7'd0, sys_rst_n}, 8'h1);
    end

    // R4 strap disable keeps the timer idle
    nclk(200);
    chk("R4 strap disabled no alarm", {7'd0, alarm}, 8'h0);

    // R3 / R5 / R7 timeout of 3 ticks
    mode_byte = 8'h65; strap_code = 5'h0A; strap_wd_en = 1'b1;
    wr_tmr(8'd3);
    nclk(23);
    chk("R3 before expiry", {7'd0, alarm}, 8'h0);
    nclk(1);
    chk("R3 at expiry", {7'd0, alarm}, 8'h1);
    chk("R7 pulse start", {7'd0, sys_rst_n}, 8'h0);
    nclk(1);
    chk("R6 strap safe code", {3'd0, freq_sel}, 8'h0A);
    chk("R5 alarm readback", {7'd0, ctl_q[5]}, 8'h1);
    nclk(2);
    chk("R7 pulse last", {7'd0, sys_rst_n}, 8'h0);
    nclk(1);
    chk("R7 pulse end", {7'd0, sys_rst_n}, 8'h1);

    // R6 programmed safe code, R9 write of 1 keeps alarm
    mode_byte = 8'h6D;
    wr_ctl(8'h65);
    chk("R9 bit5=1 keeps alarm", {7'd0, alarm}, 8'h1);
    nclk(1);
    chk("R6 programmed safe code", {3'd0, freq_sel}, 8'h05);
    wr_ctl(8'h45);
    chk("R9 bit5=0 clears alarm", {7'd0, alarm}, 8'h0);
    nclk(1);
    chk("R9 normal code back", {3'd0, freq_sel}, 8'h16);

    // R10 re-arm on the expiring edge
    wr_tmr(8'd1);
    nclk(7);
    wr_tmr(8'd1);
    chk("R10 collision no alarm", {7'd0, alarm}, 8'h0);
    chk("R10 collision no pulse", {7'd0, sys_rst_n}, 8'h1);
    nclk(7);
    chk("R10 fresh count pending", {7'd0, alarm}, 8'h0);
    nclk(1);
    chk("R3 count one expiry", {7'd0, alarm}, 8'h1);

    // R3 zero count, R9 timer write clears alarm
    wr_tmr(8'd0);
    chk("R9 timer write clears", {7'd0, alarm}, 8'h0);
    nclk(7);
    chk("R3 zero before tick", {7'd0, alarm}, 8'h0);
    nclk(1);
    chk("R3 zero count expiry", {7'd0, alarm}, 8'h1);

    // R4 control bit overrides strap enable
    wr_ctl(8'h05);
    wr_tmr(8'd1);
    nclk(30);
    chk("R4 ctl disable overrides strap", {7'd0, alarm}, 8'h0);
    wr_ctl(8'h45);
    nclk(7);
    chk("R4 enable before tick", {7'd0, alarm}, 8'h0);
    nclk(1);
    chk("R4 ctl enable expiry", {7'd0, alarm}, 8'h1);

    // R8 reset on frequency change
    wr_ctl(8'h05);
    nclk(8);
    rst_on_chg = 1'b1;
    mode_byte = 8'h57;
    nclk(1);
    chk("R8 code changed", {3'd0, freq_sel}, 8'h1D);
    chk("R8 pulse on change", {7'd0, sys_rst_n}, 8'h0);
    nclk(3);
    chk("R8 pulse held", {7'd0, sys_rst_n}, 8'h0);
    nclk(1);
    chk("R8 pulse ends", {7'd0, sys_rst_n}, 8'h1);
    rst_on_chg = 1'b0;
    mode_byte = 8'h13;
    nclk(1);
    chk("R8 change without enable", {3'd0, freq_sel}, 8'h09);
    chk("R8 no pulse", {7'd0, sys_rst_n}, 8'h1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule